// File: doc/BRIEF.md
# Large Warp Sub-warp Former

This block sits between the decode stage and a SIMD pipeline of `LANES` lanes. It accepts the active mask of one large warp, which holds `LANES*ROWS` threads, and splits it into sub-warps that the pipeline can issue one at a time. The block views the mask as a grid with one column per SIMD lane. For each sub-warp it searches every column on its own, so threads from different rows can share one sub-warp. For each lane it reports a valid bit and the row of the thread it chose.

The large-warp mask enters through a valid/ready handshake. `in_ready` is high only while the block holds no warp, so a new mask can be accepted only in an idle cycle. A producer that raises `in_valid` keeps the mask and the branch-type bit stable until the mask is accepted.

Sub-warps leave through a second valid/ready handshake. While `out_valid` is high and `out_ready` is low, the current sub-warp is held unchanged. When a sub-warp is accepted, the next one is available in the following cycle, so the block forms one sub-warp per cycle.

`out_last` marks the final sub-warp, which lets the front end decide when a conditional branch may be re-fetched. `done` is a one-cycle pulse that follows the completion of each warp.

Top module: `subwarp_former`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `done` is 0. `in_ready` is 1 exactly when no warp is held, and a mask is accepted on a cycle where `in_valid` and `in_ready` are both 1.
- R2: In each sub-warp, lane c has `out_lane_vld[c]`=1 and carries in `out_lane_row[c*3 +: 3]` the lowest-numbered row of column c that is still active. A lane whose column has no active thread left has valid 0 and row 0.
- R3: Thread t of `in_mask` (bit t) belongs to row t / LANES and column (lane) t mod LANES.
- R4: The threads selected by an accepted sub-warp are removed from the held mask. For a non-zero mask taken with `in_uncond`=0, the number of sub-warps equals the largest count of active threads in any single column.
- R5: `out_last` is 1 on the final sub-warp of a warp and 0 on every earlier one.
- R6: A non-zero mask accepted with `in_uncond`=1 yields exactly one sub-warp. That sub-warp has the lane and row contents that R2 gives for the whole mask, and it carries `out_last`=1.
- R7: An all-zero mask, once accepted, yields no sub-warp. In the next cycle `done` is 1 and `in_ready` is 1.
- R8: `done` is 1 for exactly the one cycle after the final sub-warp is accepted. In that cycle `out_valid` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, the lane valids, the rows and `out_last` hold their values and `out_valid` stays 1.
- R10: With `out_ready` held at 1, the sub-warps of one warp appear in consecutive cycles: a warp needing N sub-warps occupies the output for exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Large-warp mask offered |
| in_ready | output | 1 | Block is idle and takes a mask |
| in_mask | input | LANES*ROWS | Active mask, bit t = thread t |
| in_uncond | input | 1 | Warp is at an unconditional branch |
| out_valid | output | 1 | Sub-warp available |
| out_ready | input | 1 | Pipeline takes the sub-warp |
| out_lane_vld | output | LANES | Per-lane thread valid |
| out_lane_row | output | LANES*3 | Per-lane row index, 3 bits per lane |
| out_last | output | 1 | Final sub-warp of this warp |
| done | output | 1 | One-cycle pulse after a warp completes |

## Verification
Random dense masks produce full sub-warps in the first cycles and ragged ones at the end. Sparse masks, made by ANDing several random words, separate a per-column search from a row-by-row slicing, because rows that are packed together must not each take a cycle of their own. Directed cases isolate specific behaviour:
- a single thread checks the index mapping;
- a full column forces the maximum count of eight sub-warps;
- a full mask checks the all-lanes case;
- an empty mask checks the immediate completion;
- unconditional warps check the single-issue path.

Random stalls on `out_ready` check that the output holds steady under back-pressure. Stall-free runs check that one sub-warp leaves per cycle.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_EMIT = 1'b1
  } sw_state_e;
endpackage

// File: rtl/sw_col_pick.sv
// Lowest-set-bit search over one lane column.
module sw_col_pick #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 3
) (
  input  logic [ROWS-1:0]  col,
  output logic             hit,
  output logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  onehot
);
  always_comb begin
    hit = 1'b0;
    row = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (col[r]) begin
        hit = 1'b1;
        row = r[ROW_W-1:0];
      end
    end
    onehot = hit ? (ROWS'(1) << row) : '0;
  end
endmodule

// File: rtl/sw_mask_store.sv
// Working copy of the large-warp mask, kept column-major.
module sw_mask_store #(
  parameter int LANES = 32,
  parameter int ROWS  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [LANES*ROWS-1:0] load_mask,
  input  logic                  upd,
  input  logic [LANES*ROWS-1:0] clr,
  output logic [LANES*ROWS-1:0] work
);
  logic [LANES*ROWS-1:0] col_major;

  // Thread r*LANES+c goes to column c, row r.
  for (genvar c = 0; c < LANES; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col_major[c*ROWS + r] = load_mask[r*LANES + c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    work <= '0;
    else if (load) work <= col_major;
    else if (upd)  work <= work & ~clr;
  end
endmodule

// File: rtl/subwarp_former.sv
module subwarp_former #(
  parameter int LANES = 32,
  parameter int ROWS  = 8,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int THREADS = LANES * ROWS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [THREADS-1:0]     in_mask,
  input  logic                   in_uncond,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES-1:0]       out_lane_vld,
  output logic [LANES*ROW_W-1:0] out_lane_row,
  output logic                   out_last,
  output logic                   done
);
  import sw_pkg::*;

  sw_state_e state_q;
  logic uncond_q;
  logic done_q;
  logic [THREADS-1:0] work;
  logic [THREADS-1:0] pick_clr;
  logic [THREADS-1:0] clr_eff;
  logic take_in, take_out, in_empty;

  assign in_ready  = (state_q == SW_IDLE);
  assign out_valid = (state_q == SW_EMIT);
  assign take_in   = in_valid && in_ready;
  assign take_out  = out_valid && out_ready;
  assign in_empty  = ~|in_mask;

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    sw_col_pick #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pick (
      .col    (work[c*ROWS +: ROWS]),
      .hit    (out_lane_vld[c]),
      .row    (out_lane_row[c*ROW_W +: ROW_W]),
      .onehot (pick_clr[c*ROWS +: ROWS])
    );
  end

  // Unconditional warps finish after one sub-warp, so that sub-warp clears all.
  assign out_last = uncond_q || ((work & ~pick_clr) == '0);
  assign clr_eff  = out_last ? '1 : pick_clr;

  sw_mask_store #(.LANES(LANES), .ROWS(ROWS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_in),
    .load_mask (in_mask),
    .upd       (take_out),
    .clr       (clr_eff),
    .work      (work)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SW_IDLE;
      uncond_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (take_in && in_empty) || (take_out && out_last);
      case (state_q)
        SW_IDLE: if (take_in && !in_empty) begin
          state_q  <= SW_EMIT;
          uncond_q <= in_uncond;
        end
        SW_EMIT: if (take_out && out_last) begin
          state_q  <= SW_IDLE;
          uncond_q <= 1'b0;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign done = done_q;
endmodule

// File: rtl/subwarp_former_chk.sv
module subwarp_former_chk #(
  parameter int LANES = 32,
  parameter int ROWS  = 8,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int THREADS = LANES * ROWS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [THREADS-1:0]     in_mask,
  input logic                   in_uncond,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES-1:0]       out_lane_vld,
  input logic [LANES*ROW_W-1:0] out_lane_row,
  input logic                   out_last,
  input logic                   done
);
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != out_valid);

  assert_some_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> |out_lane_vld);

  assert_more_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);

  assert_single_uncond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_uncond && |in_mask) |=> (out_valid && out_last));

  assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ~|in_mask) |=> (done && !out_valid));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lane_vld)
      && $stable(out_lane_row) && $stable(out_last)));
endmodule

bind subwarp_former subwarp_former_chk #(.LANES(LANES), .ROWS(ROWS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_mask      (in_mask),
  .in_uncond    (in_uncond),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_lane_vld (out_lane_vld),
  .out_lane_row (out_lane_row),
  .out_last     (out_last),
  .done         (done)
);

// File: tb/subwarp_former_tb.sv
module subwarp_former_tb;
  localparam int LANES = 32;
  localparam int ROWS = 8;
  localparam int RW = 3;
  localparam int THREADS = LANES * ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [THREADS-1:0] in_mask = '0;
  logic in_uncond = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [LANES-1:0] out_lane_vld;
  logic [LANES*RW-1:0] out_lane_row;
  logic out_last;
  logic done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  subwarp_former #(.LANES(LANES), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_uncond(in_uncond), .out_valid(out_valid),
    .out_ready(out_ready), .out_lane_vld(out_lane_vld),
    .out_lane_row(out_lane_row), .out_last(out_last), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sub-warp model: lowest active row of every column.
  function automatic void model_pick(input logic [THREADS-1:0] m,
                                     output logic [LANES-1:0] v,
                                     output logic [LANES*RW-1:0] rw,
                                     output logic [THREADS-1:0] sel);
    v = '0; rw = '0; sel = '0;
    for (int c = 0; c < LANES; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        if (!v[c] && m[r*LANES + c]) begin
          v[c] = 1'b1;
          rw[c*RW +: RW] = RW'(r);
          sel[r*LANES + c] = 1'b1;
        end
      end
    end
  endfunction

  function automatic int model_count(input logic [THREADS-1:0] m, input bit unc);
    int best = 0;
    if (m == '0) return 0;
    if (unc) return 1;
    for (int c = 0; c < LANES; c++) begin
      int n = 0;
      for (int r = 0; r < ROWS; r++) n += int'(m[r*LANES + c]);
      if (n > best) best = n;
    end
    return best;
  endfunction

  task automatic run_warp(input logic [THREADS-1:0] mask, input bit unc,
                          input int stall_pct);
    logic [THREADS-1:0] model;
    logic [LANES-1:0] ev;
    logic [LANES*RW-1:0] er;
    logic [THREADS-1:0] sel;
    int nsub = 0;
    int ncyc = 0;
    int exp_n;
    bit last_e;
    bit finished = 1'b0;
    exp_n = model_count(mask, unc);
    @(negedge clk);
    in_valid = 1'b1; in_mask = mask; in_uncond = unc;
    #1 check(in_ready == 1'b1, "R1 idle accepts", 256'(in_ready), 256'(1));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_mask = '0; in_uncond = 1'b0;
    model = mask;
    if (mask == '0) begin
      #1;
      check(done == 1'b1, "R7 done on empty", 256'(done), 256'(1));
      check(out_valid == 1'b0, "R7 no sub-warp", 256'(out_valid), 256'(0));
      check(in_ready == 1'b1, "R7 ready again", 256'(in_ready), 256'(1));
      return;
    end
    while (!finished && ncyc < 200) begin
      out_ready = (($urandom % 100) >= stall_pct);
      #1;
      ncyc++;
      model_pick(model, ev, er, sel);
      last_e = unc || ((model & ~sel) == '0);
      check(out_valid == 1'b1, "R4 sub-warp pending", 256'(out_valid), 256'(1));
      check(in_ready == 1'b0, "R1 busy refuses", 256'(in_ready), 256'(0));
      check(out_lane_vld == ev, "R2/R3 lane valid", 256'(out_lane_vld), 256'(ev));
      check(out_lane_row == er, "R2/R3 lane row", 256'(out_lane_row), 256'(er));
      check(out_last == last_e, "R5 last flag", 256'(out_last), 256'(last_e));
      check(done == 1'b0, "R8 no early done", 256'(done), 256'(0));
      if (out_ready) begin
        nsub++;
        model = unc ? '0 : (model & ~sel);
        finished = last_e;
      end
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1;
    check(done == 1'b1, "R8 done pulse", 256'(done), 256'(1));
    check(out_valid == 1'b0, "R8 output idle", 256'(out_valid), 256'(0));
    check(nsub == exp_n, unc ? "R6 single issue" : "R4 sub-warp count",
          256'(nsub), 256'(exp_n));
    if (stall_pct == 0)
      check(ncyc == exp_n, "R10 one per cycle", 256'(ncyc), 256'(exp_n));
    @(negedge clk);
    #1 check(done == 1'b0, "R8 done one cycle", 256'(done), 256'(0));
  endtask

  function automatic logic [THREADS-1:0] rand_mask();
    logic [THREADS-1:0] m;
    for (int i = 0; i < THREADS / 32; i++) m[i*32 +: 32] = $urandom;
    return m;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1 reset ready", 256'(in_ready), 256'(1));
    check(out_valid == 1'b0, "R1 reset valid", 256'(out_valid), 256'(0));
    check(done == 1'b0, "R1 reset done", 256'(done), 256'(0));

    // R3: thread 37 is row 1, lane 5.
    run_warp(THREADS'(1) << 37, 1'b0, 0);
    // R7: empty mask.
    run_warp('0, 1'b0, 0);
    run_warp('0, 1'b1, 0);
    // R4: one full column needs ROWS sub-warps.
    begin
      logic [THREADS-1:0] m = '0;
      for (int r = 0; r < ROWS; r++) m[r*LANES + 9] = 1'b1;
      run_warp(m, 1'b0, 0);
    end
    // Full mask and a single full row.
    run_warp('1, 1'b0, 0);
    run_warp({{(THREADS-LANES){1'b0}}, {LANES{1'b1}}} << (3*LANES), 1'b0, 0);
    // R6: unconditional warps.
    run_warp('1, 1'b1, 0);
    run_warp(rand_mask(), 1'b1, 40);
    // Random dense and sparse, with and without R9 back-pressure.
    for (int i = 0; i < 40; i++) begin
      logic [THREADS-1:0] m = rand_mask();
      if (i % 2 == 1) m = m & rand_mask() & rand_mask();
      run_warp(m, 1'b0, (i % 3 == 0) ? 0 : 50);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule